// File: doc/BRIEF.md
# Next-Marked-Slot Scheduling Counter

This block is a scheduling pointer that does not step by one. Each time it is told to advance, it moves from its present value to the nearest slot above it whose bit is set in a run-time eligibility mask. Unmarked slots are passed over. The search wraps from the highest slot back to slot 0 and continues up toward the present value. The block therefore acts as a round-robin pointer over whichever slots are eligible in that cycle.

The mask is sampled in the same cycle as the advance request, and it may change on every cycle. The present slot is the last candidate in the wrapped search order. So when only the present slot is marked, the pointer stays where it is. When no slot is marked, the pointer goes to 0. A separate combinational flag reports whether any slot is marked at all. The slot count is a power-of-two parameter with a default of 16, which gives a 4-bit pointer.

Top module: `marked_slot_counter`

## Requirements
- R1: While `rst` is high at a rising edge of `clk`, `count` becomes 0 at that edge, whatever `advance` and `mask` are.
- R2: When `advance` is low at a rising edge and `rst` is low, `count` keeps its value, whatever `mask` is.
- R3: When `advance` is high at a rising edge and `rst` is low, `count` takes the value (count+k) mod SLOTS for the smallest k in 1..SLOTS for which bit (count+k) mod SLOTS of `mask` is set. Bit i of `mask` marks slot i. For example, from count 2 with only bits 1 and 5 set, the next count is 5.
- R4: The search wraps around. If no marked slot lies above the present count, the lowest marked slot below it is chosen. For example, from count 14 with only bits 3 and 9 set, the next count is 3.
- R5: If the only set bit of `mask` is the bit of the present count, an advance leaves `count` unchanged.
- R6: If `mask` is all zeros at an advance, `count` becomes 0.
- R7: `any_marked` is 1 exactly when at least one bit of `mask` is set, in the same cycle and without any clock delay.
- R8: Only the `mask` value present at the advancing edge affects the result. Different masks in the cycles before that edge, while `advance` is low, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| advance | input | 1 | Move to the next marked slot at this edge |
| mask | input | SLOTS (16) | Eligibility mask; bit i marks slot i |
| count | output | log2(SLOTS) (4) | Current slot pointer |
| any_marked | output | 1 | High when any mask bit is set |

## Verification
The pointer register is the only state in the block. A wrong value in it shows on `count` right after the edge that produced it. Because every later jump starts from the present slot, the same error also moves every later landing point. The bench walks every starting slot against several hundred masks per start, and it compares each jump with a cyclic scan computed in the bench. A wrong search order, a wrong wrap, or a wrong self-slot priority therefore appears on the first advance that uses it. It also exercises hold periods while the mask changes, an empty mask, masks with only the present slot marked, and reset applied from a non-zero count.

// File: rtl/marked_slot_counter.sv
module marked_slot_counter #(
  parameter int SLOTS = 16,
  localparam int CW = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             advance,
  input  logic [SLOTS-1:0] mask,
  output logic [CW-1:0]    count,
  output logic             any_marked
);

  logic [CW-1:0] nxt;

  // Scan slots count+1 .. count+SLOTS (mod SLOTS); the first marked one wins.
  // count+SLOTS folds back to count itself, so the own slot is tried last.
  always_comb begin
    logic          hit;
    logic [CW-1:0] idx;
    nxt = '0;
    hit = 1'b0;
    for (int k = 1; k <= SLOTS; k++) begin
      idx = count + CW'(k);
      if (!hit && mask[idx]) begin
        nxt = idx;
        hit = 1'b1;
      end
    end
  end

  assign any_marked = |mask;

  always_ff @(posedge clk) begin
    if (rst)          count <= '0;
    else if (advance) count <= nxt;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable(count));

  p_lands_marked_r3: assert property (@(posedge clk) disable iff (rst)
    (advance && any_marked) |=> ((($past(mask) >> count) & SLOTS'(1)) != '0));

  p_self_only_r5: assert property (@(posedge clk) disable iff (rst)
    (advance && mask == (SLOTS'(1) << count)) |=> $stable(count));

  p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (advance && !any_marked) |=> (count == '0));

endmodule

// File: tb/tb_marked_slot_counter.sv
`timescale 1ns/1ps
module tb_marked_slot_counter;
  localparam int SLOTS = 16;
  localparam int CW = 4;

  logic             clk = 1'b0;
  logic             rst;
  logic             advance;
  logic [SLOTS-1:0] mask;
  logic [CW-1:0]    count;
  logic             any_marked;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  marked_slot_counter #(.SLOTS(SLOTS)) dut (
    .clk(clk), .rst(rst), .advance(advance), .mask(mask),
    .count(count), .any_marked(any_marked)
  );

  function automatic int ref_next(int cur, logic [SLOTS-1:0] m);
    for (int k = 1; k <= SLOTS; k++) begin
      int idx = (cur + k) % SLOTS;
      if (m[idx]) return idx;
    end
    return 0;
  endfunction

  task automatic chk(int act, int exp, string req);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic a, logic [SLOTS-1:0] m);
    @(negedge clk);
    rst = r; advance = a; mask = m;
    @(posedge clk);
    #1;
  endtask

  task automatic put_at(int s);
    step(1'b0, 1'b1, SLOTS'(1) << s);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [31:0] lcg = 32'h1234_5678;
    rst = 1'b1; advance = 1'b1; mask = 16'hA5A5;
    repeat (3) step(1'b1, 1'b1, 16'hA5A5);
    chk(count, 0, "R1 reset state");

    // R7 combinational flag, sampled mid-cycle
    @(negedge clk); rst = 1'b0; advance = 1'b0; mask = '0;
    #1 chk(any_marked, 0, "R7 empty flag");
    mask = 16'h8000;
    #1 chk(any_marked, 1, "R7 top bit flag");
    mask = 16'h0001;
    #1 chk(any_marked, 1, "R7 bottom bit flag");

    // R3 example and R4 wrap example
    put_at(2);
    chk(count, 2, "R5 placement");
    step(1'b0, 1'b1, 16'h0022);
    chk(count, 5, "R3 example 2->5");
    put_at(14);
    step(1'b0, 1'b1, 16'h0208);
    chk(count, 3, "R4 wrap 14->3");
    put_at(15);
    step(1'b0, 1'b1, 16'h0001);
    chk(count, 0, "R4 wrap top->0");

    // R5 own slot only, R6 empty mask, R2/R8 hold with changing masks
    for (int s = 0; s < SLOTS; s++) begin
      put_at(s);
      step(1'b0, 1'b1, SLOTS'(1) << s);
      chk(count, s, "R5 own slot only");
      for (int h = 0; h < 3; h++) begin
        step(1'b0, 1'b0, 16'hFFFF ^ (SLOTS'(1) << s) ^ SLOTS'(h));
        chk(count, s, "R2 hold");
      end
      step(1'b0, 1'b1, SLOTS'(1) << ((s + 3) % SLOTS));
      chk(count, (s + 3) % SLOTS, "R8 mask at advance edge");
      put_at(s);
      step(1'b0, 1'b1, '0);
      chk(count, 0, "R6 empty mask");
    end

    // R3/R4 sweep: every start against many masks
    for (int s = 0; s < SLOTS; s++) begin
      for (int t = 0; t < 600; t++) begin
        logic [SLOTS-1:0] m;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        m = lcg[31:16];
        if (t < SLOTS) m = SLOTS'(1) << t;
        else if (t < 2 * SLOTS) m = ~(SLOTS'(1) << (t - SLOTS));
        put_at(s);
        @(negedge clk); advance = 1'b1; mask = m;
        #1 chk(any_marked, (m != 0) ? 1 : 0, "R7 flag sweep");
        @(posedge clk); #1;
        chk(count, ref_next(s, m), (ref_next(s, m) > s) ? "R3 sweep" : "R4 sweep");
      end
    end

    // R1 reset from non-zero count
    put_at(9);
    step(1'b1, 1'b1, 16'h0400);
    chk(count, 0, "R1 reset mid-run");

    done = 1;
    report();
  end
endmodule